// File: doc/BRIEF.md
# Clock-Generator Control Register Slave on a Two-Wire Bus

This block is the serial control port of a clock generator. It watches a two-wire SMBus (clock line and open-drain data line), sampled by a faster system clock. It recognises its own write and read addresses and holds a bank of nine 8-bit control registers. The registers are exported as a flat parallel bus to the rest of the chip. Four externally latched frequency-select straps come in as read-only status and appear inverted in the read-back of one register.

There is no register pointer. A write always carries a command byte and a byte-count byte first. The slave acknowledges both and discards them, then fills registers from index 0 upward. A read always begins with the fixed byte-count value, followed by register 0, register 1, and so on, until the master declines to acknowledge. The slave only drives the data line low: for its acknowledge bits and for the zero bits of read data. It releases the line otherwise.

Top module: `clkgen_smbus_regs`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. The read/write flag is bit 0, where 1 means read. The slave pulls the data line low during the ninth clock.
- R2: Any other address byte gets no acknowledge. The data line stays released until the next START, and no register changes.
- R3: In a write, the two bytes after the address (command, then count) are acknowledged and have no effect. Each later byte, received MSB first, is stored in register 0, 1, 2, … in turn and acknowledged.
- R4: In a read, the first byte shifted out (MSB first) is the count value 9. Register 0, register 1, … follow. Any byte requested past the last register reads 0x00.
- R5: The slave changes the data line only while the clock line is low.
- R6: A master that does not acknowledge a read byte ends the read. The slave then releases the data line until the next START.
- R7: After reset, register 0 is 0x00, registers 1 to 5 are 0xFF, register 6 is 0x04, and registers 7 and 8 are 0x00. The data line is released.
- R8: Write bytes beyond register 8 are acknowledged and discarded. A register changes only when a complete data byte addressed to it has been received.
- R9: A STOP (data rising while clock is high) at any point returns the slave to idle and releases the line. Registers written earlier keep their values, and a partly received byte is dropped.
- R10: Read-back of register 5 returns the inverted strap inputs in bits 5..2 (strap bit 3 in bit 5, down to strap bit 0 in bit 2). The other bits come from the stored value. The parallel output always carries the stored value.
- R11: A START issued in the middle of a transfer (repeated START) restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_i | input | 4 | Latched hardware frequency-select straps, read-only |
| cfg_o | output | 72 | Register bank, register i in bits 8i+7..8i |

## Verification
Checks run on every cycle cover the following:
- The data-line driver becomes active only while the synchronised clock is low.
- The driver is released after a STOP and whenever the slave is idle or ignoring the bus.
- A register write never targets an index past the bank.
- The register outputs hold still unless a write strobe precedes them.

The byte-level behaviour can only be shown by the bench's bus transactions:
- the discarded command and count bytes;
- the ordering of the count byte and registers on read;
- the inverted strap read-back;
- dropping a byte cut short by STOP;
- ignoring a foreign address.

// File: rtl/clkgen_smb_pkg.sv
package clkgen_smb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WBYTE,
    S_WACK,
    S_RBYTE,
    S_RACK,
    S_SKIP
  } smb_state_t;

  // 7-bit device address; the 8-bit forms are 0xD2 (write) and 0xD3 (read)
  localparam logic [6:0] DEV_ADDR = 7'h69;

  // register holding the inverted strap read-back field
  localparam int STRAP_REG = 5;
  localparam int STRAP_LSB = 2;

  function automatic logic [7:0] reg_default(input int idx);
    logic [7:0] v;
    if (idx >= 1 && idx <= 5) v = 8'hFF;
    else if (idx == 6)        v = 8'h04;
    else                      v = 8'h00;
    return v;
  endfunction

endpackage

// File: rtl/clkgen_smb_sync.sv
module clkgen_smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic [STAGES-1:0] scl_d, sda_d;
  logic              scl_prev_q, sda_prev_q;

  // shift chains, idle bus level is high
  generate
    if (STAGES == 1) begin : g_one
      assign scl_d = scl_i;
      assign sda_d = sda_i;
    end else begin : g_many
      assign scl_d = {scl_q[STAGES-2:0], scl_i};
      assign sda_d = {sda_q[STAGES-2:0], sda_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= '1;
      sda_q      <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_q      <= scl_d;
      sda_q      <= sda_d;
      scl_prev_q <= scl_q[STAGES-1];
      sda_prev_q <= sda_q[STAGES-1];
    end
  end

  assign scl_lvl  = scl_q[STAGES-1];
  assign sda_lvl  = sda_q[STAGES-1];

  always_comb begin
    ev_rise  = scl_lvl & ~scl_prev_q;
    ev_fall  = ~scl_lvl & scl_prev_q;
    ev_start = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    ev_stop  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;
  end

endmodule

// File: rtl/clkgen_smb_link.sv
module clkgen_smb_link
  import clkgen_smb_pkg::*;
#(
  parameter int NUM_REGS   = 9,
  parameter int CNT_W      = 4,
  parameter int BYTE_COUNT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic [7:0]       rd_byte,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [CNT_W-1:0] rd_sel,
  output logic             sda_oe,
  output smb_state_t       state_o
);

  localparam logic [CNT_W-1:0] HDR_BYTES = CNT_W'(2);
  localparam logic [CNT_W-1:0] WCNT_MAX  = CNT_W'(NUM_REGS + 2);
  localparam logic [CNT_W-1:0] RCNT_MAX  = CNT_W'(NUM_REGS + 1);
  localparam logic [7:0]       CNT_BYTE  = 8'(BYTE_COUNT);

  smb_state_t       st_q, st_n;
  logic [2:0]       bit_q, bit_n;
  logic [7:0]       sh_q, sh_n;
  logic             ackph_q, ackph_n;
  logic             isrd_q, isrd_n;
  logic             mack_q, mack_n;
  logic             oe_q, oe_n;
  logic [CNT_W-1:0] wcnt_q, wcnt_n;
  logic [CNT_W-1:0] rcnt_q, rcnt_n;
  logic             step_en;
  logic [7:0]       byte_in;

  assign step_en = ev_start | ev_stop | ev_rise | ev_fall;
  assign byte_in = {sh_q[6:0], sda_lvl};
  assign rd_sel  = rcnt_q - CNT_W'(1);

  always_comb begin
    st_n    = st_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    ackph_n = ackph_q;
    isrd_n  = isrd_q;
    mack_n  = mack_q;
    oe_n    = oe_q;
    wcnt_n  = wcnt_q;
    rcnt_n  = rcnt_q;
    wr_en   = 1'b0;
    wr_idx  = wcnt_q - HDR_BYTES;
    wr_data = byte_in;

    if (ev_start) begin
      st_n    = S_ADDR;
      bit_n   = '0;
      oe_n    = 1'b0;
      ackph_n = 1'b0;
      wcnt_n  = '0;
      rcnt_n  = '0;
    end else if (ev_stop) begin
      st_n    = S_IDLE;
      oe_n    = 1'b0;
      ackph_n = 1'b0;
    end else begin
      unique case (st_q)
        S_ADDR: if (ev_rise) begin
          sh_n  = byte_in;
          bit_n = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            if (sh_q[6:0] == DEV_ADDR) begin
              st_n   = S_AACK;
              isrd_n = sda_lvl;
            end else begin
              st_n   = S_SKIP;
            end
          end
        end
        S_AACK: if (ev_fall) begin
          if (!ackph_q) begin
            ackph_n = 1'b1;
            oe_n    = 1'b1;
          end else begin
            ackph_n = 1'b0;
            bit_n   = '0;
            if (isrd_q) begin
              st_n   = S_RBYTE;
              sh_n   = CNT_BYTE;
              oe_n   = ~CNT_BYTE[7];
              rcnt_n = CNT_W'(1);
            end else begin
              st_n   = S_WBYTE;
              oe_n   = 1'b0;
            end
          end
        end
        S_WBYTE: if (ev_rise) begin
          sh_n  = byte_in;
          bit_n = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            st_n = S_WACK;
            if (wcnt_q >= HDR_BYTES && wcnt_q < WCNT_MAX) wr_en = 1'b1;
            if (wcnt_q != WCNT_MAX) wcnt_n = wcnt_q + CNT_W'(1);
          end
        end
        S_WACK: if (ev_fall) begin
          if (!ackph_q) begin
            ackph_n = 1'b1;
            oe_n    = 1'b1;
          end else begin
            ackph_n = 1'b0;
            oe_n    = 1'b0;
            bit_n   = '0;
            st_n    = S_WBYTE;
          end
        end
        S_RBYTE: if (ev_fall) begin
          if (bit_q == 3'd7) begin
            oe_n  = 1'b0;
            bit_n = '0;
            st_n  = S_RACK;
          end else begin
            sh_n  = {sh_q[6:0], 1'b0};
            oe_n  = ~sh_q[6];
            bit_n = bit_q + 3'd1;
          end
        end
        S_RACK: begin
          if (ev_rise) mack_n = ~sda_lvl;
          if (ev_fall) begin
            if (mack_q) begin
              st_n = S_RBYTE;
              sh_n = rd_byte;
              oe_n = ~rd_byte[7];
              if (rcnt_q != RCNT_MAX) rcnt_n = rcnt_q + CNT_W'(1);
            end else begin
              st_n = S_SKIP;
              oe_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ackph_q <= 1'b0;
      isrd_q  <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
    end else if (step_en) begin
      st_q    <= st_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      ackph_q <= ackph_n;
      isrd_q  <= isrd_n;
      mack_q  <= mack_n;
      oe_q    <= oe_n;
      wcnt_q  <= wcnt_n;
      rcnt_q  <= rcnt_n;
    end
  end

  assign sda_oe  = oe_q;
  assign state_o = st_q;

endmodule

// File: rtl/clkgen_smb_regbank.sv
module clkgen_smb_regbank
  import clkgen_smb_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int CNT_W    = 4,
  parameter int STRAP_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CNT_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [CNT_W-1:0]      rd_sel,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [7:0]            rd_data
);

  logic [7:0] reg_q [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] RST_VAL = reg_default(g);
      logic hit;
      assign hit = wr_en && (wr_idx == CNT_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   reg_q[g] <= RST_VAL;
        else if (hit) reg_q[g] <= wr_data;
      end
      assign regs_o[g*8 +: 8] = reg_q[g];
    end
  endgenerate

  // read-back multiplexer, strap field substituted in one register
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel == CNT_W'(i)) rd_data = reg_q[i];
    end
    if (rd_sel == CNT_W'(STRAP_REG)) begin
      rd_data[STRAP_LSB +: STRAP_W] = ~strap_i;
    end
  end

endmodule

// File: rtl/clkgen_smbus_regs.sv
module clkgen_smbus_regs
  import clkgen_smb_pkg::*;
#(
  parameter int NUM_REGS    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  localparam int CNT_W      = $clog2(NUM_REGS + 3);
  localparam int BYTE_COUNT = NUM_REGS;

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic             scl_lvl, sda_lvl;
  logic             ev_start, ev_stop, ev_rise, ev_fall;
  logic             wr_en;
  logic [CNT_W-1:0] wr_idx, rd_sel;
  logic [7:0]       wr_data, rd_byte;
  logic             sda_oe;
  smb_state_t       link_state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  clkgen_smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall)
  );

  clkgen_smb_link #(
    .NUM_REGS   (NUM_REGS),
    .CNT_W      (CNT_W),
    .BYTE_COUNT (BYTE_COUNT)
  ) u_link (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .sda_lvl  (sda_lvl),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .rd_byte  (rd_byte),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .sda_oe   (sda_oe),
    .state_o  (link_state)
  );

  clkgen_smb_regbank #(
    .NUM_REGS (NUM_REGS),
    .CNT_W    (CNT_W),
    .STRAP_W  (STRAP_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .strap_i (strap_i),
    .regs_o  (cfg_o),
    .rd_data (rd_byte)
  );

  assign sda_pull_o = sda_oe;

endmodule

// File: rtl/clkgen_smbus_regs_chk.sv
module clkgen_smbus_regs_chk
  import clkgen_smb_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int CNT_W    = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_lvl,
  input logic                  ev_start,
  input logic                  ev_stop,
  input logic                  sda_oe,
  input smb_state_t            state,
  input logic                  wr_en,
  input logic [CNT_W-1:0]      wr_idx,
  input logic [NUM_REGS*8-1:0] cfg
);

  p_pull_only_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  p_release_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_lvl || $past(ev_stop) || $past(ev_start)));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> !sda_oe);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  p_wr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < CNT_W'(NUM_REGS)));

  p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));

endmodule

bind clkgen_smbus_regs clkgen_smbus_regs_chk #(
  .NUM_REGS (NUM_REGS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_i),
  .scl_lvl  (scl_lvl),
  .ev_start (ev_start),
  .ev_stop  (ev_stop),
  .sda_oe   (sda_oe),
  .state    (link_state),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .cfg      (cfg_o)
);

// File: tb/clkgen_smbus_regs_test.sv
module clkgen_smbus_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 9;
  localparam int Q          = 4;   // system clocks per quarter bus bit

  logic             clk = 1'b0;
  logic             rst_n;
  logic             scl_m, sda_m;
  logic             sda_pull;
  logic [3:0]       strap;
  logic [NREG*8-1:0] cfg;
  wire              sda_bus = sda_m & ~sda_pull;

  int n_cmp = 0;
  int n_bad = 0;
  int r5_viol = 0;
  bit done = 0;

  logic [7:0] mdl [NREG];
  logic [7:0] rbuf [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_smbus_regs uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_pull_o (sda_pull),
    .strap_i    (strap),
    .cfg_o      (cfg)
  );

  function automatic logic [7:0] dflt(input int i);
    if (i >= 1 && i <= 5) return 8'hFF;
    if (i == 6) return 8'h04;
    return 8'h00;
  endfunction

  function automatic logic [7:0] rb_exp(input int i);
    logic [7:0] v;
    if (i >= NREG) return 8'h00;
    v = mdl[i];
    if (i == 5) v[5:2] = ~strap;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R5 monitor: the pull may only change while the bus clock is low
  logic pull_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && sda_pull !== pull_prev && scl_m === 1'b1) r5_viol++;
    pull_prev <= sda_pull;
  end

  task automatic xbit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    r = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(d[i], r);
    xbit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xbit(1'b1, r);
      d[i] = r;
    end
    xbit(~give_ack, r);
  endtask

  // full write: address, command, count, n data bytes; returns all-acked flag
  task automatic wr_txn(input int n, input logic [7:0] cmd, output logic all_ack);
    logic a;
    all_ack = 1'b1;
    bstart();
    send(8'hD2, a); all_ack &= a;
    send(cmd, a);   all_ack &= a;
    send(8'(n), a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      send(rbuf[i], a); all_ack &= a;
      if (i < NREG) mdl[i] = rbuf[i];
    end
    bstop();
  endtask

  task automatic rd_txn(input int n, output logic addr_ack);
    bstart();
    send(8'hD3, addr_ack);
    for (int i = 0; i < n; i++) recv(i != n-1, rbuf[i]);
    bstop();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic a, r;
    logic [7:0] d;
    void'($urandom(32'h5EED_0C1C));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 4'b0110;
    for (int i = 0; i < NREG; i++) mdl[i] = dflt(i);
    tick(6);
    rst_n = 1'b1;
    tick(6);

    // R7: reset values and released line
    for (int i = 0; i < NREG; i++) chk($sformatf("R7 reg%0d", i), 32'(cfg[i*8 +: 8]), 32'(dflt(i)));
    chk("R7 line released", 32'(sda_pull), 32'd0);

    // R1/R3: directed write of three bytes; command/count contents ignored
    rbuf[0] = 8'h5A; rbuf[1] = 8'h00; rbuf[2] = 8'hC3;
    wr_txn(3, 8'h07, a);
    chk("R1 R3 write acks", 32'(a), 32'd1);
    for (int i = 0; i < NREG; i++) chk($sformatf("R3 reg%0d", i), 32'(cfg[i*8 +: 8]), 32'(mdl[i]));

    // R4/R10/R1: full read incl. one byte past the bank
    strap = 4'b1010;
    rd_txn(NREG + 2, a);
    chk("R1 read addr ack", 32'(a), 32'd1);
    chk("R4 count byte", 32'(rbuf[0]), 32'd9);
    for (int i = 0; i <= NREG; i++) chk($sformatf("R4 R10 byte reg%0d", i), 32'(rbuf[i+1]), 32'(rb_exp(i)));

    // R10: parallel output keeps stored reg5, read-back inverts straps
    rbuf[0]=8'h11; rbuf[1]=8'h22; rbuf[2]=8'h33; rbuf[3]=8'h44; rbuf[4]=8'h55; rbuf[5]=8'hA5;
    wr_txn(6, 8'hFF, a);
    chk("R10 stored reg5", 32'(cfg[47:40]), 32'h000000A5);
    strap = 4'b0011;
    rd_txn(7, a);
    chk("R10 readback reg5", 32'(rbuf[6]), 32'(8'hB1));

    // R6: NACK ends read, line stays released over further clocks
    bstart(); send(8'hD3, a); recv(1'b0, d);
    chk("R6 count before nack", 32'(d), 32'd9);
    r = 1'b1;
    for (int i = 0; i < 9; i++) begin
      logic rr; xbit(1'b1, rr); r &= rr;
    end
    chk("R6 released after nack", 32'(r), 32'd1);
    bstop();

    // R2: foreign addresses get no ack and cannot write
    bstart(); send(8'hA0, a);
    chk("R2 nack 0xA0", 32'(a), 32'd0);
    send(8'h00, a); send(8'h00, a); send(8'h00, a);
    chk("R2 no ack later", 32'(a), 32'd0);
    bstop();
    bstart(); send(8'hD0, a);
    chk("R2 nack 0xD0", 32'(a), 32'd0);
    bstop();
    for (int i = 0; i < NREG; i++) chk($sformatf("R2 reg%0d kept", i), 32'(cfg[i*8 +: 8]), 32'(mdl[i]));

    // R8: overlong write, extra bytes acked and dropped
    for (int i = 0; i < 12; i++) rbuf[i] = 8'(8'h80 + i);
    wr_txn(12, 8'h00, a);
    chk("R8 overlong acks", 32'(a), 32'd1);
    for (int i = 0; i < NREG; i++) chk($sformatf("R8 reg%0d", i), 32'(cfg[i*8 +: 8]), 32'(mdl[i]));

    // R9: stop in the middle of the second data byte
    bstart(); send(8'hD2, a); send(8'h00, a); send(8'h00, a);
    send(8'h3C, a); mdl[0] = 8'h3C;
    for (int i = 0; i < 4; i++) xbit(1'b0, r);
    bstop();
    tick(8);
    chk("R9 released", 32'(sda_pull), 32'd0);
    chk("R9 reg0 written", 32'(cfg[7:0]), 32'h3C);
    chk("R9 reg1 intact", 32'(cfg[15:8]), 32'(mdl[1]));

    // R11: repeated start switches from write to read
    bstart(); send(8'hD2, a); send(8'h12, a);
    bstart(); send(8'hD3, a);
    chk("R11 ack after restart", 32'(a), 32'd1);
    recv(1'b1, d);
    chk("R11 count after restart", 32'(d), 32'd9);
    recv(1'b0, d);
    chk("R11 reg0 after restart", 32'(d), 32'(mdl[0]));
    bstop();

    // random write/read rounds
    for (int it = 0; it < 14; it++) begin
      int n;
      n = 1 + int'($urandom_range(NREG + 1));
      for (int i = 0; i < n; i++) rbuf[i] = 8'($urandom);
      strap = 4'($urandom);
      wr_txn(n, 8'($urandom), a);
      chk("R3 random acks", 32'(a), 32'd1);
      rd_txn(NREG + 1, a);
      chk("R4 random count", 32'(rbuf[0]), 32'd9);
      for (int i = 0; i < NREG; i++) chk($sformatf("R4 random reg%0d", i), 32'(rbuf[i+1]), 32'(rb_exp(i)));
    end

    chk("R5 pull changes only with clock low", 32'(r5_viol), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule